// File: doc/BRIEF.md
# T1 Diagnostic Bit-Pattern Source

This block feeds a T1 test path with a serial stream of diagnostic bits. One of eight patterns can be chosen: sparse fixed words meant to stress timing recovery at low ones density, constant streams, a 55-octet stress sequence, two maximal-length pseudo-random sequences, and a quasi-random variant of the 20-stage sequence with its zero runs capped. A further group of codes turns the stream off.

A new pattern code is taken on a load pulse. When the code differs from the one in force, the generator goes back to the seed of the new pattern, so every selection starts at a known point. After that the block produces one bit for each cycle in which the bit strobe is high. A second output marks the first bit of each pattern period, so a receiver or a framer can lock onto the period.

Top module: `t1_pattern_gen`

## Requirements
- R1: While reset is held and after it is released, the block is in the off state and both outputs are 0.
- R2: Pattern codes: 1 off, 2 three-in-24, 3 QRSS, 4 PRBS20, 5 one-in-8, 6 PRBS15, 7 all zeros, 8 stress octets, 9 all ones. A load with a code different from the current one restarts the new pattern: at the next edge both outputs go to 0, and the next enabled bit is the first bit of the period. A load with the current code changes nothing.
- R3: Outputs are registered and change only at an edge where the strobe is high or a restarting load occurs. A restarting load takes precedence over the strobe in the same cycle and emits no bit.
- R4: Codes 1, 0 and 10 to 15 give the off state: data and period flag stay 0 whatever the strobe does.
- R5: Three-in-24 repeats a 24-bit word whose bits 0, 4 and 8 (in sending order, bit 0 first) are 1 and all others 0.
- R6: One-in-8 repeats an 8-bit word whose first bit is 1 and the other seven are 0.
- R7: PRBS20 emits o(n) = 1 for n < 20 and o(n) = o(n-20) XOR o(n-17) afterwards (polynomial x^20 + x^17 + 1, all-ones seed), period 1,048,575.
- R8: QRSS uses the PRBS20 sequence but a bit is forced to 1 whenever the 14 bits sent just before it (since the restart) were all 0, so no zero run exceeds 14.
- R9: PRBS15 emits the inverse of r(n), with r(n) = 1 for n < 15 and r(n) = r(n-15) XOR r(n-14) afterwards (x^15 + x^14 + 1, all-ones seed), period 32,767.
- R10: All-zeros mode sends constant 0 and all-ones mode constant 1, each with a period of 8 bits for the period flag.
- R11: The stress mode repeats 55 octets, 440 bits; octet i (0 to 54) is (37*i + 1) mod 256, sent most significant bit first.
- R12: In every pattern mode the period flag is 1 on the first bit of each period and 0 on every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit strobe: one output bit per high cycle |
| load | input | 1 | Takes the pattern code on `sel` |
| sel | input | 4 | Pattern code |
| data_out | output | 1 | Serial test bit |
| period_start | output | 1 | High on the first bit of each pattern period |

## Verification
Each bit appears on `data_out` and `period_start` at the clock edge that samples the strobe high, so the result of a strobe is due one edge later; a restarting load likewise shows zeros one edge later, and the first pattern bit comes at the edge of the next strobe. The bench drives inputs on the falling edge, advances its behavioural model for the following rising edge, and compares both outputs on the next falling edge, once in every cycle. Strobe gaps, simultaneous load and strobe, a repeated code and a mid-run reset move those due edges, and the model follows each of them. The PRBS15 run covers a full period, so the flag's return at bit 32,767 is checked.

// File: rtl/t1_pattern_gen.sv
module t1_pattern_gen #(
  parameter int OCT_MUL = 37,
  parameter int OCT_ADD = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       load,
  input  logic [3:0] sel,
  output logic       data_out,
  output logic       period_start
);

  localparam logic [3:0] M_OFF   = 4'd1;
  localparam logic [3:0] M_3IN24 = 4'd2;
  localparam logic [3:0] M_QRSS  = 4'd3;
  localparam logic [3:0] M_P20   = 4'd4;
  localparam logic [3:0] M_1IN8  = 4'd5;
  localparam logic [3:0] M_P15   = 4'd6;
  localparam logic [3:0] M_ZERO  = 4'd7;
  localparam logic [3:0] M_OCT   = 4'd8;
  localparam logic [3:0] M_ONE   = 4'd9;
  localparam int OCT_BITS = 55 * 8;
  localparam int CNT_W    = $clog2(OCT_BITS);
  localparam int ZCAP     = 14;

  logic [3:0]       mode;
  logic [CNT_W-1:0] cnt, last;
  logic [19:0]      s20;
  logic [14:0]      s15;
  logic [3:0]       zrun;
  logic             nxt, nps, active;

  function automatic logic oct_bit(logic [CNT_W-1:0] k);
    logic [7:0] o;
    o = 8'((int'(k >> 3) * OCT_MUL + OCT_ADD) % 256);
    return o[~k[2:0]];
  endfunction

  assign active = (mode >= M_3IN24) && (mode <= M_ONE);

  always_comb begin
    case (mode)
      M_3IN24: last = CNT_W'(23);
      M_OCT:   last = CNT_W'(OCT_BITS - 1);
      M_1IN8, M_ZERO, M_ONE: last = CNT_W'(7);
      default: last = '0;
    endcase
  end

  always_comb begin
    nxt = 1'b0;
    nps = 1'b0;
    case (mode)
      M_3IN24: begin
        nxt = (cnt == '0) || (cnt == CNT_W'(4)) || (cnt == CNT_W'(8));
        nps = (cnt == '0);
      end
      M_QRSS: begin
        nxt = s20[19] | (zrun == 4'(ZCAP));
        nps = &s20;
      end
      M_P20: begin
        nxt = s20[19];
        nps = &s20;
      end
      M_1IN8: begin
        nxt = (cnt == '0);
        nps = (cnt == '0);
      end
      M_P15: begin
        nxt = ~s15[14];
        nps = &s15;
      end
      M_ZERO: nps = (cnt == '0);
      M_OCT: begin
        nxt = oct_bit(cnt);
        nps = (cnt == '0);
      end
      M_ONE: begin
        nxt = 1'b1;
        nps = (cnt == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || (load && sel != mode)) begin
      mode         <= rst ? M_OFF : sel;
      cnt          <= '0;
      s20          <= '1;
      s15          <= '1;
      zrun         <= '0;
      data_out     <= 1'b0;
      period_start <= 1'b0;
    end else if (bit_en) begin
      data_out     <= nxt;
      period_start <= nps;
      cnt          <= (cnt == last) ? '0 : cnt + 1'b1;
      if (mode == M_QRSS || mode == M_P20)
        s20 <= {s20[18:0], s20[19] ^ s20[16]};
      if (mode == M_P15)
        s15 <= {s15[13:0], s15[14] ^ s15[13]};
      if (mode == M_QRSS)
        zrun <= nxt ? '0 : zrun + 1'b1;
    end
  end

  a_r4_off_silent: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!data_out && !period_start));

  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !load) |=> ($stable(data_out) && $stable(period_start)));

  a_r2_restart_clears: assert property (@(posedge clk) disable iff (rst)
    (load && sel != mode) |=> (!data_out && !period_start));

  a_r8_forced_one: assert property (@(posedge clk) disable iff (rst)
    (mode == M_QRSS && zrun == 4'(ZCAP) && bit_en && !load) |=> data_out);

  a_r8_run_bound: assert property (@(posedge clk) disable iff (rst)
    zrun <= 4'(ZCAP));

  a_r10_ones_steady: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ONE && bit_en && !load) |=> data_out);

  a_r10_zeros_steady: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ZERO && bit_en && !load) |=> !data_out);

  a_r12_flag_needs_pattern: assert property (@(posedge clk) disable iff (rst)
    period_start |-> active);

endmodule

// File: tb/sim_t1_pattern_gen.sv
module sim_t1_pattern_gen;
  logic clk = 1'b0;
  logic rst = 1'b1, bit_en = 1'b0, load = 1'b0;
  logic [3:0] sel = 4'd0;
  logic data_out, period_start;

  t1_pattern_gen u0 (.clk(clk), .rst(rst), .bit_en(bit_en), .load(load),
                     .sel(sel), .data_out(data_out), .period_start(period_start));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0, armed = 0;
  int m_mode = 1, m_z = 0, run0 = 0, maxrun = 0;
  longint m_idx = 0;
  bit hist[$];
  bit exp_d = 0, exp_p = 0;
  string tag = "R1";

  function automatic longint period_of(int m);
    case (m)
      2: return 24;
      3, 4: return 1048575;
      6: return 32767;
      8: return 440;
      5, 7, 9: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic model_edge(bit r, bit ld, int s, bit en);
    bit raw, b;
    int k, oct;
    if (r || (ld && s != m_mode)) begin
      m_mode = r ? 1 : s;
      m_idx = 0; m_z = 0; hist.delete();
      exp_d = 0; exp_p = 0;
      return;
    end
    if (!en) return;
    if (m_mode < 2 || m_mode > 9) begin
      exp_d = 0; exp_p = 0;
      return;
    end
    k = int'(m_idx % period_of(m_mode));
    case (m_mode)
      2: b = (k == 0 || k == 4 || k == 8);
      3, 4: begin
        raw = (m_idx < 20) ? 1'b1 : hist[m_idx-20] ^ hist[m_idx-17];
        hist.push_back(raw);
        b = raw;
        if (m_mode == 3) begin
          if (m_z >= 14) b = 1;
          m_z = b ? 0 : m_z + 1;
        end
      end
      5: b = (k == 0);
      6: begin
        raw = (m_idx < 15) ? 1'b1 : hist[m_idx-15] ^ hist[m_idx-14];
        hist.push_back(raw);
        b = ~raw;
      end
      7: b = 0;
      8: begin
        oct = (37 * (k / 8) + 1) % 256;
        b = (oct >> (7 - k % 8)) & 1;
      end
      default: b = 1;
    endcase
    exp_d = b;
    exp_p = (k == 0);
    m_idx++;
  endtask

  task automatic cyc(bit r, bit ld, int s, bit en);
    @(negedge clk);
    if (armed) begin
      checks++;
      if (data_out !== exp_d || period_start !== exp_p) begin
        fails++;
        $display("FAIL %s: mode %0d bit %0d data/flag actual %b/%b expected %b/%b",
                 tag, m_mode, m_idx, data_out, period_start, exp_d, exp_p);
      end
      if (m_mode == 3 && data_out === 1'b0) run0++; else run0 = 0;
      if (run0 > maxrun) maxrun = run0;
    end
    rst = r; load = ld; sel = 4'(s); bit_en = en;
    model_edge(r, ld, s, en);
    armed = 1;
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++)
      cyc(0, 0, 0, (gap == 0) ? 1'b1 : (i % gap != gap - 1));
  endtask

  task automatic pick(int s, bit en, string t);
    tag = t;
    cyc(0, 1, s, en);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 195000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    tag = "R1";
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 1); cyc(1, 1, 2, 1);
    cyc(0, 0, 0, 0); run(4, 0);
    tag = "R4";                        // code 1 with strobes: silent
    run(10, 0);
    pick(2, 0, "R5"); run(80, 3);      // R5 with strobe gaps (R3)
    pick(2, 1, "R2"); run(30, 0);      // R2 same code, no restart
    pick(5, 1, "R3"); run(40, 2);      // R3 load beats strobe; R6
    tag = "R6"; run(20, 0);
    pick(4, 0, "R7"); run(4000, 0);
    pick(3, 1, "R8"); run(100000, 0);
    tag = "R8"; checks++;
    if (maxrun > 14) begin
      fails++;
      $display("FAIL R8: longest zero run actual %0d expected <= 14", maxrun);
    end
    pick(6, 0, "R9"); run(32800, 0);   // R9 and R12 flag after full period
    pick(7, 0, "R10"); run(20, 0);
    pick(9, 0, "R10"); run(20, 4);
    pick(8, 0, "R11"); run(900, 0);
    tag = "R12"; run(10, 0);
    pick(1, 1, "R4"); run(12, 0);
    pick(0, 0, "R4"); run(12, 0);
    pick(12, 1, "R4"); run(12, 0);
    pick(9, 0, "R2"); run(5, 0);
    tag = "R1"; cyc(1, 0, 0, 1); cyc(0, 0, 0, 1); run(6, 0);
    @(negedge clk);
    finish_up();
  end
endmodule